// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (1 KiB)

This block is a synchronous two-wire bus slave that behaves like a 1024-byte serial EEPROM. It oversamples the bus clock and data lines with the system clock. It finds START and STOP conditions, compares the device byte with a fixed identity and one strap input, and takes a word address. It serves byte writes, page writes of up to sixteen bytes, random reads and sequential reads. Written bytes are first collected in a page buffer. They reach the storage array only at the end of a self-timed write cycle, and that cycle starts with the STOP that closes the transaction.

The data line is split into a sampled input `sda_i` and an open-drain pull-down enable `sda_oe_o`. The surrounding logic resolves the wired-AND. While the write cycle runs, the slave does not acknowledge its device byte, so a master can poll for completion. A write-lock input protects the upper 512 bytes of the array.

Top module: `serial_nvm_slave`

## Requirements
- R1: After reset `sda_oe_o` is low and every array byte reads as 0xFF.
- R2: A device byte is acknowledged only when its bits 7:4 equal 1010 and bit 3 equals `strap_i`. Any other device byte gets no acknowledge, and the slave stays silent until the next START.
- R3: In the device byte, bits 2:1 carry word address bits 9:8 and bit 0 selects read (1) or write (0). In a write, the next byte gives address bits 7:0. A read device byte replaces address bits 9:8 with its own bits 2:1. A byte write followed by a random read returns the written value.
- R4: In a page write each data byte goes to the current address, and only the low four address bits then increment, wrapping inside the 16-byte page. Bytes after the sixteenth overwrite earlier bytes of the same page, and no byte lands outside the page.
- R5: Buffered data is committed only when a STOP arrives on a byte boundary after at least one complete data byte. A STOP in the middle of a byte, or a repeated START, discards the whole transaction.
- R6: A committing STOP starts a write cycle of `WR_CYCLES` clocks. During that cycle the device byte gets no acknowledge; after it the device byte is acknowledged again.
- R7: While `wp_i` is high, data bytes addressed to 512..1023 are still acknowledged but never stored. Addresses 0..511 are written normally.
- R8: A sequential read returns consecutive bytes and increments the full 10-bit address after each byte the master acknowledges, wrapping from 1023 to 0. A master NACK ends the read and releases the line.
- R9: `sda_oe_o` only changes while the bus clock is low and is low after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved bus data line |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| strap_i | input | 1 | Device-select strap compared with device byte bit 3 |
| wp_i | input | 1 | Write lock for the upper half of the array |

## Verification
The write path is exercised with a single byte, with an 18-byte page burst that starts two bytes before the page end, with a burst to the locked half, and with transactions cut short by a mid-byte STOP or a repeated START. The 18-byte burst tells in-page wrap and overwrite apart from spilling into the next page, because the byte just past the page is read back as well. Sequential reads across the 255/256 boundary and across 1023/0 tell a full 10-bit increment apart from an 8-bit or in-page one. Polling right after each committing STOP tells a running write cycle apart from an idle device, and polling after an aborted transaction shows that the abort never started a write cycle.

// File: rtl/snvm_pkg.sv
`timescale 1ns/1ps
package snvm_pkg;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } ctl_state_e;
endpackage

// File: rtl/snvm_bus_sampler.sv
`timescale 1ns/1ps
module snvm_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int QW = SYNC_STAGES + 1;

  logic [QW-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[QW-2:0], scl_i};
      sda_q <= {sda_q[QW-2:0], sda_i};
    end
  end

  assign scl_s = scl_q[QW-2];
  assign scl_p = scl_q[QW-1];
  assign sda_s = sda_q[QW-2];
  assign sda_p = sda_q[QW-1];

  assign sda_o   = sda_s;
  assign rise_o  = scl_s & ~scl_p;
  assign fall_o  = ~scl_s & scl_p;
  // data edges while the clock stays high
  assign start_o = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/snvm_proto.sv
`timescale 1ns/1ps
module snvm_proto
  import snvm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PG_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic              strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              buf_we_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              buf_clr_o,
  output logic              commit_o,
  output logic              sda_oe_o
);
  localparam int BLK_W = ADDR_W - 8;

  ctl_state_e        state;
  logic [2:0]        cnt;
  logic [6:0]        sh;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] addr;
  logic [BLK_W-1:0]  blk;
  logic              ack_pend, in_ack, ld_pend, have_data, oe;
  logic [7:0]        byte_in;
  logic              byte_end, dev_hit, load_now;

  assign byte_in  = {sh, sda_i};
  assign byte_end = rise_i && !in_ack && cnt == 3'd7;
  assign dev_hit  = byte_in[7:4] == DEV_ID && byte_in[3] == strap_i && !busy_i;
  assign load_now = fall_i && !ack_pend &&
                    ((in_ack && state == ST_RDATA) || (!in_ack && ld_pend));

  assign buf_we_o   = byte_end && state == ST_WDATA && !(wp_i && addr[ADDR_W-1]);
  assign buf_addr_o = addr;
  assign buf_data_o = byte_in;
  assign buf_clr_o  = start_i;
  // the stop's own clock high phase samples one bit: cnt==1 marks a byte boundary
  assign commit_o   = stop_i && state == ST_WDATA && cnt == 3'd1 && have_data && !in_ack;
  assign rd_addr_o  = addr;
  assign sda_oe_o   = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '1;
      addr      <= '0;
      blk       <= '0;
      ack_pend  <= 1'b0;
      in_ack    <= 1'b0;
      ld_pend   <= 1'b0;
      have_data <= 1'b0;
      oe        <= 1'b0;
    end else if (start_i || stop_i) begin
      state     <= start_i ? ST_DEV : ST_IDLE;
      cnt       <= '0;
      ack_pend  <= 1'b0;
      in_ack    <= 1'b0;
      ld_pend   <= 1'b0;
      have_data <= 1'b0;
      oe        <= 1'b0;
    end else if (rise_i && !in_ack) begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          sh  <= byte_in[6:0];
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (state == ST_DEV) begin
              if (dev_hit) begin
                ack_pend <= 1'b1;
                if (byte_in[0]) begin
                  state                      <= ST_RDATA;
                  addr[ADDR_W-1:ADDR_W-BLK_W] <= byte_in[BLK_W:1];
                end else begin
                  state <= ST_ADDR;
                  blk   <= byte_in[BLK_W:1];
                end
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              addr     <= {blk, byte_in};
              ack_pend <= 1'b1;
              state    <= ST_WDATA;
            end else begin
              ack_pend        <= 1'b1;
              have_data       <= 1'b1;
              addr[PG_W-1:0]  <= addr[PG_W-1:0] + PG_W'(1);
            end
          end
        end
        ST_RDATA: begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) state <= ST_RACK;
        end
        ST_RACK: begin
          if (!sda_i) begin
            addr    <= addr + ADDR_W'(1);
            state   <= ST_RDATA;
            ld_pend <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end else if (fall_i) begin
      if (ack_pend) begin
        oe       <= 1'b1;
        ack_pend <= 1'b0;
        in_ack   <= 1'b1;
      end else begin
        in_ack  <= 1'b0;
        ld_pend <= 1'b0;
        if (load_now) begin
          oe <= ~rd_data_i[7];
          tx <= {rd_data_i[6:0], 1'b1};
        end else if (in_ack || state == ST_RACK) begin
          oe <= 1'b0;
        end else if (state == ST_RDATA) begin
          oe <= ~tx[7];
          tx <= {tx[6:0], 1'b1};
        end
      end
    end
  end

  // R9
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(fall_i));
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  // R6
  busy_noack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && !in_ack && state == ST_DEV && cnt == 3'd7 && busy_i
    |=> state == ST_IDLE && !ack_pend);
endmodule

// File: rtl/snvm_store.sv
`timescale 1ns/1ps
module snvm_store #(
  parameter int ADDR_W    = 10,
  parameter int PG_W      = 4,
  parameter int WR_CYCLES = 1200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_clr_i,
  input  logic              buf_we_i,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [7:0]        buf_data_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PG_W;
  localparam int TW         = $clog2(WR_CYCLES + 1);

  logic [7:0]             mem   [MEM_BYTES];
  logic [7:0]             pdata [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  pvalid;
  logic [ADDR_W-PG_W-1:0] page;
  logic [TW-1:0]          tmr;
  logic                   done;

  assign busy_o    = tmr != '0;
  assign done      = tmr == TW'(1);
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tmr <= '0;
    else if (commit_i && !busy_o) tmr <= TW'(WR_CYCLES);
    else if (busy_o)             tmr <= tmr - TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvalid <= '0;
      page   <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pdata[i] <= '1;
    end else if (done || (buf_clr_i && !busy_o)) begin
      pvalid <= '0;
    end else if (buf_we_i && !busy_o) begin
      pdata[buf_addr_i[PG_W-1:0]]  <= buf_data_i;
      pvalid[buf_addr_i[PG_W-1:0]] <= 1'b1;
      page                         <= buf_addr_i[ADDR_W-1:PG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvalid[i]) mem[{page, PG_W'(i)}] <= pdata[i];
    end
  end

  // R6
  commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_o);
  // R6
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_o);
  // R5
  no_fill_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !buf_we_i);
endmodule

// File: rtl/serial_nvm_slave.sv
`timescale 1ns/1ps
module serial_nvm_slave #(
  parameter int MEM_BYTES   = 1024,
  parameter int PAGE_BYTES  = 16,
  parameter int WR_CYCLES   = 1200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic strap_i,
  input  logic wp_i
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PG_W   = $clog2(PAGE_BYTES);

  logic              sda_s, rise, fall, start, stop;
  logic              busy, buf_we, buf_clr, commit;
  logic [ADDR_W-1:0] rd_addr, buf_addr;
  logic [7:0]        rd_data, buf_data;

  snvm_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_o   (sda_s),
    .rise_o  (rise),
    .fall_o  (fall),
    .start_o (start),
    .stop_o  (stop)
  );

  snvm_proto #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_s),
    .strap_i    (strap_i),
    .wp_i       (wp_i),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .buf_we_o   (buf_we),
    .buf_addr_o (buf_addr),
    .buf_data_o (buf_data),
    .buf_clr_o  (buf_clr),
    .commit_o   (commit),
    .sda_oe_o   (sda_oe_o)
  );

  snvm_store #(.ADDR_W(ADDR_W), .PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .buf_clr_i  (buf_clr),
    .buf_we_i   (buf_we),
    .buf_addr_i (buf_addr),
    .buf_data_i (buf_data),
    .commit_i   (commit),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .busy_o     (busy)
  );
endmodule

// File: tb/sim_serial_nvm_slave.sv
`timescale 1ns/1ps
module sim_serial_nvm_slave;
  localparam int WR_CYC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_line;
  logic sda_oe;
  int   checks = 0;
  int   fails = 0;
  int   viol = 0;
  logic oe_prev = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] rbuf [0:31];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  serial_nvm_slave #(.WR_CYCLES(WR_CYC)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .strap_i  (1'b1),
    .wp_i     (wp)
  );

  // R9 monitor: output edges must not fall in the clock-high phase
  always @(posedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(4);
    scl_m = 1'b1; wclk(8);
    sda_m = 1'b0; wclk(8);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(4);
    scl_m = 1'b1; wclk(8);
    sda_m = 1'b1; wclk(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wclk(4);
    scl_m = 1'b1; wclk(8);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wclk(4);
    scl_m = 1'b1; wclk(4);
    b = sda_line; wclk(4);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!mack);
  endtask

  function automatic logic [7:0] dev(input logic [9:0] a, input logic rd);
    return {4'b1010, 1'b1, a[9:8], rd};
  endfunction

  task automatic do_write(input logic [9:0] a, input int n, input logic [7:0] base, output bit ok);
    bit ack;
    ok = 1'b1;
    bus_start();
    wr_byte(dev(a, 1'b0), ack); ok &= ack;
    wr_byte(a[7:0], ack);       ok &= ack;
    for (int i = 0; i < n; i++) begin
      wr_byte(base + 8'(i), ack); ok &= ack;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [9:0] a, input int n, output bit ok);
    bit ack;
    ok = 1'b1;
    bus_start();
    wr_byte(dev(a, 1'b0), ack); ok &= ack;
    wr_byte(a[7:0], ack);       ok &= ack;
    bus_start();
    wr_byte(dev(a, 1'b1), ack); ok &= ack;
    for (int i = 0; i < n; i++) rd_byte(rbuf[i], i < n - 1);
    bus_stop();
  endtask

  task automatic poll(output int tries);
    bit ack;
    tries = 0;
    for (int i = 0; i < 10; i++) begin
      tries++;
      bus_start();
      wr_byte(dev(10'h000, 1'b0), ack);
      bus_stop();
      if (ack) break;
    end
  endtask

  task automatic t_reset();
    bit ok;
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    do_read(10'h005, 1, ok);
    chk(ok, "R1 read acks", ok, 1);
    chk(rbuf[0] == 8'hFF, "R1 erased byte", rbuf[0], 8'hFF);
  endtask

  task automatic t_match();
    bit ack;
    bus_start();
    wr_byte(8'b1010_0_00_0, ack);
    bus_stop();
    chk(!ack, "R2 strap mismatch nack", ack, 0);
    bus_start();
    wr_byte(8'b1011_1_00_0, ack);
    bus_stop();
    chk(!ack, "R2 wrong id nack", ack, 0);
    bus_start();
    wr_byte(8'b1010_1_00_0, ack);
    bus_stop();
    chk(ack, "R2 match ack", ack, 1);
  endtask

  task automatic t_byte();
    bit ok;
    int tries;
    do_write(10'h155, 1, 8'h3C, ok);
    chk(ok, "R3 byte write acks", ok, 1);
    poll(tries);
    chk(tries > 1, "R6 busy after commit", tries, 2);
    chk(tries < 10, "R6 ready after cycle", tries, 2);
    do_read(10'h155, 1, ok);
    chk(rbuf[0] == 8'h3C, "R3 random read", rbuf[0], 8'h3C);
    do_read(10'h055, 1, ok);
    chk(rbuf[0] == 8'hFF, "R3 block bits select", rbuf[0], 8'hFF);
  endtask

  task automatic t_page();
    bit ok;
    int tries;
    logic [7:0] e;
    do_write(10'h02E, 18, 8'hA0, ok);
    chk(ok, "R4 page write acks", ok, 1);
    poll(tries);
    chk(tries > 1, "R6 busy after page", tries, 2);
    do_read(10'h020, 17, ok);
    for (int j = 0; j < 16; j++) begin
      e = (j < 14) ? 8'(8'hA2 + j) : 8'(8'hB0 + j - 14);
      chk(rbuf[j] == e, $sformatf("R4 page byte %0d", j), rbuf[j], e);
    end
    chk(rbuf[16] == 8'hFF, "R4 no spill past page", rbuf[16], 8'hFF);
  endtask

  task automatic t_abort();
    bit ack, ok;
    int tries;
    bus_start();
    wr_byte(dev(10'h040, 1'b0), ack);
    wr_byte(8'h40, ack);
    wr_byte(8'h11, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    poll(tries);
    chk(tries == 1, "R5 mid-byte stop no cycle", tries, 1);
    do_read(10'h040, 1, ok);
    chk(rbuf[0] == 8'hFF, "R5 mid-byte stop no write", rbuf[0], 8'hFF);
    bus_start();
    wr_byte(dev(10'h041, 1'b0), ack);
    wr_byte(8'h41, ack);
    wr_byte(8'h22, ack);
    bus_start();
    wr_byte(dev(10'h041, 1'b1), ack);
    rd_byte(rbuf[0], 1'b0);
    bus_stop();
    chk(ack, "R5 restart read acks", ack, 1);
    poll(tries);
    chk(tries == 1, "R5 restart no cycle", tries, 1);
    do_read(10'h041, 1, ok);
    chk(rbuf[0] == 8'hFF, "R5 restart discards", rbuf[0], 8'hFF);
  endtask

  task automatic t_wp();
    bit ok;
    int tries;
    wp = 1'b1;
    do_write(10'h250, 1, 8'h77, ok);
    chk(ok, "R7 locked data still acked", ok, 1);
    poll(tries);
    do_write(10'h050, 1, 8'h66, ok);
    poll(tries);
    wp = 1'b0;
    do_read(10'h250, 1, ok);
    chk(rbuf[0] == 8'hFF, "R7 upper half unchanged", rbuf[0], 8'hFF);
    do_read(10'h050, 1, ok);
    chk(rbuf[0] == 8'h66, "R7 lower half written", rbuf[0], 8'h66);
  endtask

  task automatic t_seq();
    bit ok;
    int tries;
    logic b;
    do_write(10'h3FF, 1, 8'h5A, ok); poll(tries);
    do_write(10'h000, 1, 8'hC3, ok); poll(tries);
    do_write(10'h0FF, 1, 8'h12, ok); poll(tries);
    do_write(10'h100, 1, 8'h34, ok); poll(tries);
    do_read(10'h3FF, 2, ok);
    chk(rbuf[0] == 8'h5A, "R8 byte at 1023", rbuf[0], 8'h5A);
    chk(rbuf[1] == 8'hC3, "R8 wrap to 0", rbuf[1], 8'hC3);
    do_read(10'h0FF, 2, ok);
    chk(rbuf[1] == 8'h34, "R8 carry into bit 8", rbuf[1], 8'h34);
    // NACK ends the read: line stays released afterwards
    bus_start();
    wr_byte(dev(10'h000, 1'b1), ok);
    rd_byte(rbuf[0], 1'b0);
    recv_bit(b);
    chk(b == 1'b1, "R8 released after nack", b, 1);
    bus_stop();
  endtask

  task automatic t_release();
    bit ok;
    do_write(10'h060, 1, 8'h01, ok);
    wclk(4);
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    chk(viol == 0, "R9 no change while clock high", viol, 0);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_match();
    t_byte();
    t_page();
    t_abort();
    t_wp();
    t_seq();
    t_release();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule